// File: doc/BRIEF.md
# Serial-port frame-sync pin multiplexer

This block owns the two frame-sync pins of a synchronous serial audio port: the receive-side pin (pin 0) and the transmit-side pin (pin 1). Based on the port's control bits, it decides what each pin does. A pin can carry a frame sync in either direction, act as a general-purpose serial flag, act as an external transmit buffer enable, or serve as a plain GPIO bit. The block drives each pin's output value and output enable. It hands the receiver and the transmitter the frame syncs they should use. It also keeps a latched copy of the output flag and a captured input flag.

In asynchronous mode each direction has its own frame sync. In synchronous mode both directions share the transmit-side frame sync, and pin 0 is freed to act as a flag or a buffer enable. Flag values move only on framing events. In normal mode the event is a frame-sync strobe. In network mode it is a slot strobe. The surrounding port supplies the internal frame syncs, the framing strobes and the active-slot indication. Serial shifting, clock generation and register access are outside this block.

Top module: `fspin_mux`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `pin_oe` bits, both `pin_o` bits and `if_flag` read 0 after that edge, whatever the configuration inputs are.
- R2: When `pin_func[0]`=1 and `cfg_sync`=0, pin 0 is the receive frame sync. If `cfg_rdir`=1, the pin drives `fs_rx_int` with `pin_oe[0]`=1 and `rx_fs` equals `fs_rx_int`. If `cfg_rdir`=0, the pin is an input (`pin_oe[0]`=0) and `rx_fs` follows `pin_i[0]` combinationally.
- R3: When `pin_func[1]`=1, pin 1 is the transmit frame sync. If `cfg_tdir`=1, it drives `fs_tx_int`, and if `cfg_tdir`=0 it is an input. `tx_fs` is the resulting sync value. When `cfg_sync`=1, `rx_fs` equals `tx_fs`. When `pin_func[1]`=0, `tx_fs` is 0.
- R4: With `pin_func[0]`=1, `cfg_sync`=1, `cfg_bufen`=0 and `cfg_rdir`=1, pin 0 is an output flag and shows a latched copy of `of_bit`. The copy is reloaded only on a framing event: `frame_evt` when `cfg_net`=0, or `slot_evt` when `cfg_net`=1. The other strobe has no effect.
- R5: With `pin_func[0]`=1, `cfg_sync`=1, `cfg_bufen`=0 and `cfg_rdir`=0, pin 0 is an input flag (`pin_oe[0]`=0). On a framing event, selected as in R4, `if_flag` loads the value of `pin_i[0]` after a two-stage synchronizer. `if_flag` holds at all other times and in every other mode.
- R6: With `pin_func[0]`=1, `cfg_sync`=1, `cfg_bufen`=1 and `cfg_rdir`=1, pin 0 is the buffer enable with `pin_oe[0]`=1. Its value is `tx_slot_act` AND `tx_run`, so it is 0 whenever `tx_run`=0. With `cfg_bufen`=1 and `cfg_rdir`=0, the pin is undriven.
- R7: When `pin_func[i]`=0, pin i is GPIO, and its mode is `gpio_mode[2i+1:2i]`: 00 disconnected, 01 input, 10 output, 11 disconnected. In output mode the pin drives `gpio_out[i]` with the enable set. In input mode the enable is off and `gpio_in[i]` is `pin_i[i]` after two synchronizer stages. When disconnected, the enable is off and `gpio_in[i]` is 0. `gpio_in[i]` is also 0 whenever `pin_func[i]`=1.
- R8: `pin_o` and `pin_oe` are registered. They take the value selected by the inputs and latched flag of the previous cycle, and an undriven pin has `pin_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sync | input | 1 | 1 = synchronous mode |
| cfg_bufen | input | 1 | 1 = pin 0 used as buffer enable in synchronous mode |
| cfg_rdir | input | 1 | Pin 0 direction, 1 = output |
| cfg_tdir | input | 1 | Pin 1 direction, 1 = output |
| cfg_net | input | 1 | 1 = network mode (slot strobe is the framing event) |
| pin_func | input | 2 | Per pin, 1 = serial-port function, 0 = GPIO |
| gpio_mode | input | 4 | Two bits per pin, GPIO mode encoding |
| gpio_out | input | 2 | GPIO output values |
| of_bit | input | 1 | Output flag control bit |
| tx_run | input | 1 | Transmitter out of reset |
| fs_rx_int | input | 1 | Internally generated receive frame sync |
| fs_tx_int | input | 1 | Internally generated transmit frame sync |
| frame_evt | input | 1 | Frame-sync event strobe |
| slot_evt | input | 1 | Slot boundary strobe |
| tx_slot_act | input | 1 | Transmitter active slot |
| pin_i | input | 2 | Pin input values |
| pin_o | output | 2 | Pin output values |
| pin_oe | output | 2 | Pin output enables |
| rx_fs | output | 1 | Frame sync used by the receiver |
| tx_fs | output | 1 | Frame sync used by the transmitter |
| if_flag | output | 1 | Captured input flag |
| gpio_in | output | 2 | Synchronized GPIO inputs |

## Verification
Two things can happen in the same cycle: a framing event that reloads or captures a flag, and a change in the configuration or in the selected pin input. An input toggling on the same edge as a capture must yield the old synchronized value. A switch between normal and network mode decides which strobe counts in that cycle. The random phase drives `frame_evt`, `slot_evt`, `pin_i` and `of_bit` independently every cycle, so coincident and disjoint strobes both occur often. The directed phase fires each strobe alone in each mode. A cycle-level reference model in the bench judges every output on every cycle.

// File: rtl/fspin_pkg.sv
// Package: shared encodings for the frame-sync pin multiplexer.
// Assumes two pins: index 0 is the receive-side pin, index 1 the transmit side.
package fspin_pkg;
    localparam int NPINS = 2;

    // GPIO mode field per pin.
    typedef enum logic [1:0] {
        GP_OFF  = 2'b00,
        GP_IN   = 2'b01,
        GP_OUT  = 2'b10,
        GP_OFF2 = 2'b11
    } gpio_mode_t;

    // Role taken by the receive-side pin under serial-port ownership.
    typedef enum logic [2:0] {
        RP_FS_OUT,
        RP_FS_IN,
        RP_FLAG_OUT,
        RP_FLAG_IN,
        RP_BUF_EN,
        RP_IDLE
    } rx_role_t;
endpackage

// File: rtl/fspin_sync.sv
// Module: multi-stage synchronizer for a vector of pin inputs.
// Assumes STAGES >= 2; reset clears every stage to 0.
module fspin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fspin_gpio_cell.sv
// Module: GPIO cell for one frame-sync pin.
// Decides the GPIO drive and gates the raw pin input. A disconnected
// pin reads 0 internally. Assumes the caller overrides drive when the
// serial port owns the pin.
module fspin_gpio_cell
    import fspin_pkg::*;
(
    input  logic       owned,     // serial port owns the pin
    input  logic [1:0] mode,
    input  logic       drv_val,
    input  logic       pin_raw,
    input  logic       synced,    // synchronized gated input
    output logic       gated,     // raw input after disconnect gating
    output logic       gp_oe,
    output logic       gp_o,
    output logic       gp_in
);
    gpio_mode_t m;

    // Decode the mode field and form the GPIO-side signals.
    always_comb begin
        m     = gpio_mode_t'(mode);
        gated = (owned || m == GP_IN) ? pin_raw : 1'b0;
        gp_oe = !owned && (m == GP_OUT);
        gp_o  = gp_oe ? drv_val : 1'b0;
        gp_in = (!owned && m == GP_IN) ? synced : 1'b0;
    end
endmodule

// File: rtl/fspin_flag.sv
// Module: serial flag latch and capture.
// Picks the framing event (frame strobe in normal mode, slot strobe in
// network mode), reloads the output flag copy on it, and captures the
// synchronized pin value into the input flag when capture is enabled.
module fspin_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic net_mode,
    input  logic frame_evt,
    input  logic slot_evt,
    input  logic of_bit,
    input  logic cap_en,
    input  logic cap_val,
    output logic of_q,
    output logic if_q
);
    logic evt;

    // Select the event that paces flag transfer.
    always_comb evt = net_mode ? slot_evt : frame_evt;

    // Reload the output flag copy on each framing event.
    always_ff @(posedge clk) begin
        if (!rst_n)   of_q <= 1'b0;
        else if (evt) of_q <= of_bit;
    end

    // Capture the input flag on a framing event in input-flag mode.
    always_ff @(posedge clk) begin
        if (!rst_n)            if_q <= 1'b0;
        else if (evt && cap_en) if_q <= cap_val;
    end

    // R4: without the selected event the output flag copy holds.
    a_r4_of_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(net_mode ? slot_evt : frame_evt) |=> $stable(of_q));

    // R4: on the selected event the copy takes the control bit.
    a_r4_of_load: assert property (@(posedge clk) disable iff (!rst_n)
        (net_mode ? slot_evt : frame_evt) |=> (of_q == $past(of_bit)));

    // R5: the input flag only moves on an enabled capture.
    a_r5_if_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_en && (net_mode ? slot_evt : frame_evt)) |=> $stable(if_q));
endmodule

// File: rtl/fspin_mux.sv
// Module: frame-sync pin multiplexer, top level.
// Chooses the role of both frame-sync pins. Registers the pin drive
// (one cycle of latency, cleared by reset). Returns the receiver and
// transmitter frame syncs, synchronized GPIO inputs and the serial flags.
// Assumes the framing strobes and internal frame syncs share clk.
module fspin_mux
    import fspin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sync,
    input  logic             cfg_bufen,
    input  logic             cfg_rdir,
    input  logic             cfg_tdir,
    input  logic             cfg_net,
    input  logic [1:0]       pin_func,
    input  logic [3:0]       gpio_mode,
    input  logic [1:0]       gpio_out,
    input  logic             of_bit,
    input  logic             tx_run,
    input  logic             fs_rx_int,
    input  logic             fs_tx_int,
    input  logic             frame_evt,
    input  logic             slot_evt,
    input  logic             tx_slot_act,
    input  logic [1:0]       pin_i,
    output logic [1:0]       pin_o,
    output logic [1:0]       pin_oe,
    output logic             rx_fs,
    output logic             tx_fs,
    output logic             if_flag,
    output logic [1:0]       gpio_in
);
    localparam int W = NPINS;

    logic [W-1:0] gated, synced, gp_oe, gp_o;
    logic [W-1:0] nxt_o, nxt_oe;
    logic         of_q;
    logic         rxa_fs;
    rx_role_t     role;

    // Per-pin GPIO cells.
    for (genvar i = 0; i < W; i++) begin : g_pin
        fspin_gpio_cell u_cell (
            .owned   (pin_func[i]),
            .mode    (gpio_mode[2*i +: 2]),
            .drv_val (gpio_out[i]),
            .pin_raw (pin_i[i]),
            .synced  (synced[i]),
            .gated   (gated[i]),
            .gp_oe   (gp_oe[i]),
            .gp_o    (gp_o[i]),
            .gp_in   (gpio_in[i])
        );

        // R7: a disconnected GPIO pin is never driven.
        a_r7_off_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
            (!pin_func[i] && (gpio_mode[2*i +: 2] == 2'b00 || gpio_mode[2*i +: 2] == 2'b11))
            |=> !pin_oe[i]);
    end

    fspin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gated),
        .q     (synced)
    );

    // Role of the receive-side pin under serial-port ownership.
    always_comb begin
        if (!cfg_sync)                  role = cfg_rdir ? RP_FS_OUT : RP_FS_IN;
        else if (!cfg_bufen)            role = cfg_rdir ? RP_FLAG_OUT : RP_FLAG_IN;
        else if (cfg_rdir)              role = RP_BUF_EN;
        else                            role = RP_IDLE;
    end

    fspin_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .net_mode  (cfg_net),
        .frame_evt (frame_evt),
        .slot_evt  (slot_evt),
        .of_bit    (of_bit),
        .cap_en    (pin_func[0] && role == RP_FLAG_IN),
        .cap_val   (synced[0]),
        .of_q      (of_q),
        .if_q      (if_flag)
    );

    // Next drive of the receive-side pin.
    always_comb begin
        nxt_oe[0] = gp_oe[0];
        nxt_o[0]  = gp_o[0];
        if (pin_func[0]) begin
            unique case (role)
                RP_FS_OUT:   begin nxt_oe[0] = 1'b1; nxt_o[0] = fs_rx_int;            end
                RP_FLAG_OUT: begin nxt_oe[0] = 1'b1; nxt_o[0] = of_q;                 end
                RP_BUF_EN:   begin nxt_oe[0] = 1'b1; nxt_o[0] = tx_slot_act & tx_run; end
                default:     begin nxt_oe[0] = 1'b0; nxt_o[0] = 1'b0;                 end
            endcase
        end
    end

    // Next drive of the transmit-side pin.
    always_comb begin
        if (pin_func[1]) begin
            nxt_oe[1] = cfg_tdir;
            nxt_o[1]  = cfg_tdir & fs_tx_int;
        end else begin
            nxt_oe[1] = gp_oe[1];
            nxt_o[1]  = gp_o[1];
        end
    end

    // Register the pin drive; reset leaves both pins undriven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o  <= '0;
            pin_oe <= '0;
        end else begin
            pin_o  <= nxt_o;
            pin_oe <= nxt_oe;
        end
    end

    // Frame syncs handed to the receiver and the transmitter.
    always_comb begin
        tx_fs  = pin_func[1] ? (cfg_tdir ? fs_tx_int : gated[1]) : 1'b0;
        rxa_fs = (pin_func[0] && !cfg_sync) ? (cfg_rdir ? fs_rx_int : gated[0]) : 1'b0;
        rx_fs  = cfg_sync ? tx_fs : rxa_fs;
    end

    // R6: the buffer enable is low while the transmitter is held in reset.
    a_r6_be_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_func[0] && cfg_sync && cfg_bufen && cfg_rdir && !tx_run) |=> (pin_oe[0] && !pin_o[0]));

    // R2: an input receive frame sync reaches the receiver unchanged.
    a_r2_rx_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_func[0] && !cfg_sync && !cfg_rdir) |-> (rx_fs == pin_i[0]));

    // R8: an undriven pin carries a zero value.
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[1] |-> !pin_o[1]);
endmodule

// File: tb/test_fspin_mux.sv
module test_fspin_mux;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_sync, cfg_bufen, cfg_rdir, cfg_tdir, cfg_net;
    logic [1:0] pin_func, gpio_out, pin_i;
    logic [3:0] gpio_mode;
    logic of_bit, tx_run, fs_rx_int, fs_tx_int, frame_evt, slot_evt, tx_slot_act;
    logic [1:0] pin_o, pin_oe, gpio_in;
    logic rx_fs, tx_fs, if_flag;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fspin_mux i_fspin_mux (
        .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_bufen(cfg_bufen),
        .cfg_rdir(cfg_rdir), .cfg_tdir(cfg_tdir), .cfg_net(cfg_net),
        .pin_func(pin_func), .gpio_mode(gpio_mode), .gpio_out(gpio_out),
        .of_bit(of_bit), .tx_run(tx_run), .fs_rx_int(fs_rx_int), .fs_tx_int(fs_tx_int),
        .frame_evt(frame_evt), .slot_evt(slot_evt), .tx_slot_act(tx_slot_act),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .rx_fs(rx_fs), .tx_fs(tx_fs),
        .if_flag(if_flag), .gpio_in(gpio_in)
    );

    // Reference model state, built from the requirements.
    logic [1:0] m_s1 = '0, m_s2 = '0, m_po = '0, m_poe = '0;
    logic m_of = 1'b0, m_if = 1'b0;

    function automatic logic gp_off(input int i);
        return gpio_mode[2*i +: 2] == 2'b00 || gpio_mode[2*i +: 2] == 2'b11;
    endfunction

    function automatic logic gate_in(input int i);
        return (pin_func[i] || gpio_mode[2*i +: 2] == 2'b01) ? pin_i[i] : 1'b0;
    endfunction

    function automatic logic m_event();
        return cfg_net ? slot_evt : frame_evt;
    endfunction

    // Returns {oe, o} that pin i should take at the next edge (R2..R7).
    function automatic logic [1:0] want_pin(input int i);
        logic oe, o;
        if (!pin_func[i]) begin
            oe = gpio_mode[2*i +: 2] == 2'b10;
            o  = oe & gpio_out[i];
        end else if (i == 1) begin
            oe = cfg_tdir; o = cfg_tdir & fs_tx_int;
        end else if (!cfg_sync) begin
            oe = cfg_rdir; o = cfg_rdir & fs_rx_int;
        end else if (!cfg_bufen) begin
            oe = cfg_rdir; o = cfg_rdir & m_of;
        end else begin
            oe = cfg_rdir; o = cfg_rdir & tx_slot_act & tx_run;
        end
        return {oe, o};
    endfunction

    function automatic string pin_tag(input int i);
        if (!pin_func[i]) return "R7";
        if (i == 1) return "R3";
        if (!cfg_sync) return "R2";
        if (cfg_bufen) return "R6";
        return cfg_rdir ? "R4" : "R5";
    endfunction

    // Advance the model on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_po <= '0; m_poe <= '0; m_of <= 1'b0; m_if <= 1'b0;
        end else begin
            logic [1:0] a, b;
            a = want_pin(0); b = want_pin(1);
            m_poe <= {b[1], a[1]};
            m_po  <= {b[0], a[0]};
            m_s1  <= {gate_in(1), gate_in(0)};
            m_s2  <= m_s1;
            if (m_event()) m_of <= of_bit;
            if (m_event() && pin_func[0] && cfg_sync && !cfg_bufen && !cfg_rdir) m_if <= m_s2[0];
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output at the falling edge.
    task automatic step();
        logic ex_tx, ex_rx;
        @(negedge clk);
        n_vec++;
        ex_tx = pin_func[1] ? (cfg_tdir ? fs_tx_int : pin_i[1]) : 1'b0;
        ex_rx = cfg_sync ? ex_tx :
                (pin_func[0] ? (cfg_rdir ? fs_rx_int : pin_i[0]) : 1'b0);
        for (int i = 0; i < 2; i++) begin
            chk(pin_tag(i), "pin_oe", pin_oe[i], m_poe[i]);   // registered, R8
            chk(pin_tag(i), "pin_o", pin_o[i], m_po[i]);
            chk("R7", "gpio_in", gpio_in[i],
                (!pin_func[i] && gpio_mode[2*i +: 2] == 2'b01) ? m_s2[i] : 1'b0);
        end
        chk("R3", "tx_fs", tx_fs, ex_tx);
        chk(cfg_sync ? "R3" : "R2", "rx_fs", rx_fs, ex_rx);
        chk("R5", "if_flag", if_flag, m_if);
    endtask

    task automatic strobes_off();
        frame_evt = 0; slot_evt = 0; fs_rx_int = 0; fs_tx_int = 0; tx_slot_act = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset with every pin configured to drive.
        rst_n = 0; cfg_sync = 0; cfg_bufen = 0; cfg_rdir = 1; cfg_tdir = 1; cfg_net = 0;
        pin_func = 2'b11; gpio_mode = 4'b1010; gpio_out = 2'b11; of_bit = 1; tx_run = 1;
        fs_rx_int = 1; fs_tx_int = 1; frame_evt = 1; slot_evt = 1; tx_slot_act = 1; pin_i = 2'b11;
        repeat (3) step();
        chk("R1", "pin_oe in reset", pin_oe[0] | pin_oe[1], 1'b0);
        chk("R1", "pin_o in reset", pin_o[0] | pin_o[1], 1'b0);
        chk("R1", "if_flag in reset", if_flag, 1'b0);
        rst_n = 1; strobes_off(); of_bit = 0;
        step();

        // R4: network mode, frame strobe alone must not reload the flag.
        pin_func = 2'b11; cfg_sync = 1; cfg_bufen = 0; cfg_rdir = 1; cfg_net = 1;
        of_bit = 1; frame_evt = 1; step(); frame_evt = 0; step(); step();
        chk("R4", "flag ignores frame strobe in network mode", pin_o[0], 1'b0);
        slot_evt = 1; step(); slot_evt = 0; step();
        chk("R4", "flag loads on slot strobe", pin_o[0], 1'b1);
        // R4: normal mode, slot strobe alone ignored.
        cfg_net = 0; of_bit = 0; slot_evt = 1; step(); slot_evt = 0; step();
        chk("R4", "flag ignores slot strobe in normal mode", pin_o[0], 1'b1);

        // R5: input flag capture, pin toggles on the capture edge.
        cfg_rdir = 0; pin_i = 2'b01; repeat (3) step();
        pin_i = 2'b00; frame_evt = 1; step(); frame_evt = 0; step();
        chk("R5", "captures synchronized old value", if_flag, 1'b1);

        // R6: buffer enable with transmitter in reset.
        cfg_bufen = 1; cfg_rdir = 1; tx_slot_act = 1; tx_run = 0; step(); step();
        chk("R6", "buffer enable low while tx in reset", pin_o[0], 1'b0);
        tx_run = 1; step(); step();
        chk("R6", "buffer enable during active slot", pin_o[0], 1'b1);

        // R7: disconnected pins read 0 and are undriven.
        pin_func = 2'b00; gpio_mode = 4'b1100; pin_i = 2'b11; repeat (3) step();
        chk("R7", "disconnected gpio_in", gpio_in[0] | gpio_in[1], 1'b0);
        chk("R7", "disconnected oe", pin_oe[0] | pin_oe[1], 1'b0);

        // Random phase: configuration per epoch, strobes per cycle.
        for (int e = 0; e < 80; e++) begin
            {cfg_sync, cfg_bufen, cfg_rdir, cfg_tdir, cfg_net} = 5'($urandom);
            pin_func = 2'($urandom); gpio_mode = 4'($urandom);
            for (int c = 0; c < 25; c++) begin
                frame_evt = ($urandom % 4) == 0; slot_evt = ($urandom % 3) == 0;
                {fs_rx_int, fs_tx_int, tx_slot_act, of_bit} = 4'($urandom);
                pin_i = 2'($urandom); gpio_out = 2'($urandom);
                tx_run = ($urandom % 5) != 0;
                rst_n = !(e == 40 && c == 3);
                step();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule